// File: doc/BRIEF.md
# Cyclostationary Autocovariance Accumulator

This block gathers the running statistics needed to estimate the autocovariance of a noisy on-chip quantity that is digitized by two slow samplers. Each incoming pair carries two signed sample codes, the separation between the two sampling instants (a lag bin), and where in a repeating noise cycle the pair was taken (a phase bin). For every (lag, phase) bin the block keeps a pair count, the sum of each sampler's codes and the sum of their products. From these a host derives each sampler's mean, removes it, and obtains the covariance. Noise that is independent between the two samplers averages out of the product sum.

The noise cycle length is programmable in phase bins. A second mode serves a single sampler: it keeps per-phase count, sum and sum of squares, which gives the mean and spread of the signal at each point of the cycle. A read port returns one bin, or the sum over all phase bins of one lag, which is the time-averaged (stationary) result. A clear command wipes the whole table with a sequential pass.

Control is a two-state machine. `ST_RUN` accepts pairs and `ST_WIPE` zeroes one bin per cycle. The transition *start_wipe* (`ST_RUN` to `ST_WIPE`) fires when `clr` is sampled high. The transition *wipe_done* (`ST_WIPE` to `ST_RUN`) fires after the last bin has been zeroed. Updates pass through a two-stage read-modify-write pipeline, with forwarding between back-to-back updates to the same bin.

Top module: `acov_accum`

## Requirements
- R1: After reset every bin reads zero in all four fields, `ready` is 1 and `err` is 0.
- R2: In pair mode (`single`=0), a pair accepted with lag L < LAG_BINS and phase P < `cycle_len` (and P < PHASE_BINS) adds 1 to the count of bin (L,P), x1 to its first sum, x2 to its second sum and x1*x2 to its product sum. The codes are 12-bit two's complement and the extreme codes -2048 and 2047 must accumulate exactly.
- R3: Updates to the same bin in consecutive cycles, interleaved with updates to other bins, all accumulate with none lost.
- R4: A pair whose lag (in pair mode) or phase is out of range changes no bin. `err` goes to 1 at the clock edge that samples the pair and stays 1 until `clr`.
- R5: In single mode (`single`=1) the lag input is ignored. The pair updates bin (0,P): count +1, first sum +x1, product sum +x1*x1. The second sum is unchanged, whatever x2 is.
- R6: When `clr` is sampled, `err` is cleared, `ready` is low for exactly LAG_BINS*PHASE_BINS cycles, pairs offered meanwhile are ignored, and afterwards every bin reads zero.
- R7: Read data for an address appears one clock edge after the address is sampled. A read lag >= LAG_BINS, or a phase >= PHASE_BINS with `rd_all`=0, returns all zeros.
- R8: With `rd_all`=1, the read returns the sums over all phase bins of lag `rd_lag`, and `rd_phase` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Start clearing the whole table; also clears `err` |
| cycle_len | input | 4 | Noise cycle length in phase bins |
| single | input | 1 | 1 = one-sampler mode |
| in_valid | input | 1 | Pair present |
| in_x1 | input | 12 | First sampler code, signed |
| in_x2 | input | 12 | Second sampler code, signed |
| in_lag | input | 3 | Lag bin index |
| in_phase | input | 4 | Phase bin index |
| ready | output | 1 | High when pairs are accepted |
| err | output | 1 | Sticky dropped-pair flag |
| rd_lag | input | 3 | Read lag bin |
| rd_phase | input | 4 | Read phase bin |
| rd_all | input | 1 | Sum all phase bins of the lag |
| rd_count | output | 24 | Pair count |
| rd_sum1 | output | 35 | Sum of first codes, signed |
| rd_sum2 | output | 35 | Sum of second codes, signed |
| rd_prod | output | 47 | Sum of products, signed |

## Verification
A pair sampled at edge k sets `err` at that same edge k. Its bin is written at edge k+2, and a read address sampled at k+3 or later shows the result one edge after that. The driver therefore idles at least four cycles before reading back accumulated bins. Read requests go into a scoreboard queue tagged with the edge count at which their data is due, and a monitor compares them on the following falling edge. The wipe length is measured by counting falling edges while `ready` is low.

// File: rtl/acov_pkg.sv
package acov_pkg;
    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WIPE = 1'b1
    } acov_state_e;
endpackage

// File: rtl/acov_ctrl.sv
module acov_ctrl
    import acov_pkg::*;
#(
    parameter int NB    = 32,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic             ready,
    output logic             flush,
    output logic             wipe_en,
    output logic [IDX_W-1:0] wipe_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NB - 1);

    acov_state_e      state_q, state_d;
    logic [IDX_W-1:0] idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  if (clr) state_d = ST_WIPE;
            ST_WIPE: if (idx_q == LAST) state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   idx_q <= '0;
        else if (state_q == ST_WIPE)  idx_q <= idx_q + 1'b1;
        else                          idx_q <= '0;
    end

    always_comb begin
        ready    = 1'b0;
        wipe_en  = 1'b0;
        flush    = clr;
        unique case (state_q)
            ST_RUN:  ready = 1'b1;
            ST_WIPE: begin
                wipe_en = 1'b1;
                flush   = 1'b1;
            end
            default: ready = 1'b0;
        endcase
        wipe_idx = idx_q;
    end

    // R6: accepting stops on the cycle after a clear is sampled
    a_r6_ready_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ready) |=> !ready);
    // R6: wipe walks the bins one per cycle
    a_r6_wipe_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_en && $past(wipe_en)) |-> (wipe_idx == $past(wipe_idx) + 1'b1));
    // R6: ready only returns after the last bin was wiped
    a_r6_wipe_len: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(wipe_idx) == LAST));
endmodule

// File: rtl/acov_ingress.sv
module acov_ingress #(
    parameter int CODE_W     = 12,
    parameter int LAG_BINS   = 4,
    parameter int PHASE_BINS = 8,
    parameter int LAG_W      = 3,
    parameter int PH_W       = 4,
    parameter int IDX_W      = 5
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   accept,
    input  logic                   single,
    input  logic [PH_W-1:0]        cycle_len,
    input  logic [CODE_W-1:0]      x1,
    input  logic [CODE_W-1:0]      x2,
    input  logic [LAG_W-1:0]       lag,
    input  logic [PH_W-1:0]        phase,
    output logic                   a_vld,
    output logic [IDX_W-1:0]       a_idx,
    output logic [CODE_W-1:0]      a_d1,
    output logic [CODE_W-1:0]      a_d2,
    output logic [2*CODE_W-1:0]    a_dp,
    output logic                   drop
);
    localparam logic [LAG_W-1:0] LAG_L = LAG_W'(LAG_BINS);
    localparam logic [PH_W-1:0]  PB_L  = PH_W'(PHASE_BINS);

    logic                     take, ok, lag_ok, ph_ok;
    logic [LAG_W-1:0]         eff_lag;
    logic [CODE_W-1:0]        rhs;
    logic signed [2*CODE_W-1:0] prod;
    logic [IDX_W-1:0]         idx;

    always_comb begin
        take    = in_valid && accept;
        ph_ok   = (phase < cycle_len) && (phase < PB_L);
        lag_ok  = single || (lag < LAG_L);
        ok      = ph_ok && lag_ok;
        drop    = take && !ok;
        eff_lag = single ? '0 : lag;
        idx     = IDX_W'(eff_lag) * IDX_W'(PHASE_BINS) + IDX_W'(phase);
        rhs     = single ? x1 : x2;
        prod    = $signed(x1) * $signed(rhs);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_vld <= 1'b0;
            a_idx <= '0;
            a_d1  <= '0;
            a_d2  <= '0;
            a_dp  <= '0;
        end else begin
            a_vld <= take && ok;
            if (take) begin
                a_idx <= idx;
                a_d1  <= x1;
                a_d2  <= single ? '0 : x2;
                a_dp  <= prod;
            end
        end
    end

    // R4: a rejected pair never enters the update pipeline
    a_r4_drop_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> !a_vld);
    // R5: one-sampler updates land in lag bin 0
    a_r5_single_lag0: assert property (@(posedge clk) disable iff (!rst_n)
        (take && ok && single) |=> (a_vld && (a_idx < IDX_W'(PHASE_BINS))));
endmodule

// File: rtl/acov_bank.sv
module acov_bank #(
    parameter int NB     = 32,
    parameter int IDX_W  = 5,
    parameter int CODE_W = 12,
    parameter int CNT_W  = 21,
    parameter int SUM_W  = 32,
    parameter int PROD_W = 44
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          a_vld,
    input  logic [IDX_W-1:0]              a_idx,
    input  logic [CODE_W-1:0]             a_d1,
    input  logic [CODE_W-1:0]             a_d2,
    input  logic [2*CODE_W-1:0]           a_dp,
    input  logic                          flush,
    input  logic                          wipe_en,
    input  logic [IDX_W-1:0]              wipe_idx,
    output logic [NB-1:0][CNT_W-1:0]      cnt_mem,
    output logic [NB-1:0][SUM_W-1:0]      s1_mem,
    output logic [NB-1:0][SUM_W-1:0]      s2_mem,
    output logic [NB-1:0][PROD_W-1:0]     p_mem
);
    logic                 b_vld;
    logic [IDX_W-1:0]     b_idx;
    logic [CNT_W-1:0]     base_c, new_c;
    logic [SUM_W-1:0]     base_1, base_2, new_1, new_2;
    logic [PROD_W-1:0]    base_p, new_p;
    logic [CODE_W-1:0]    dl_1, dl_2;
    logic [2*CODE_W-1:0]  dl_p;
    logic                 fwd, wr;

    always_comb begin
        new_c = base_c + 1'b1;
        new_1 = base_1 + {{(SUM_W-CODE_W){dl_1[CODE_W-1]}}, dl_1};
        new_2 = base_2 + {{(SUM_W-CODE_W){dl_2[CODE_W-1]}}, dl_2};
        new_p = base_p + {{(PROD_W-2*CODE_W){dl_p[2*CODE_W-1]}}, dl_p};
        fwd   = b_vld && (b_idx == a_idx);
        wr    = b_vld && !flush;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_vld  <= 1'b0;
            b_idx  <= '0;
            base_c <= '0;
            base_1 <= '0;
            base_2 <= '0;
            base_p <= '0;
            dl_1   <= '0;
            dl_2   <= '0;
            dl_p   <= '0;
        end else begin
            b_vld <= a_vld && !flush;
            if (a_vld) begin
                b_idx  <= a_idx;
                base_c <= fwd ? new_c : cnt_mem[a_idx];
                base_1 <= fwd ? new_1 : s1_mem[a_idx];
                base_2 <= fwd ? new_2 : s2_mem[a_idx];
                base_p <= fwd ? new_p : p_mem[a_idx];
                dl_1   <= a_d1;
                dl_2   <= a_d2;
                dl_p   <= a_dp;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_mem <= '0;
            s1_mem  <= '0;
            s2_mem  <= '0;
            p_mem   <= '0;
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (wipe_en && (wipe_idx == IDX_W'(i))) begin
                    cnt_mem[i] <= '0;
                    s1_mem[i]  <= '0;
                    s2_mem[i]  <= '0;
                    p_mem[i]   <= '0;
                end else if (wr && (b_idx == IDX_W'(i))) begin
                    cnt_mem[i] <= new_c;
                    s1_mem[i]  <= new_1;
                    s2_mem[i]  <= new_2;
                    p_mem[i]   <= new_p;
                end
            end
        end
    end

    // R2/R3: every committed update raises that bin's count by exactly one
    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt_mem[$past(b_idx)] == CNT_W'($past(cnt_mem[b_idx]) + 1'b1)));
    // R6: a wiped bin reads zero afterwards
    a_r6_wipe_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wipe_en |=> (cnt_mem[$past(wipe_idx)] == '0 && p_mem[$past(wipe_idx)] == '0));
endmodule

// File: rtl/acov_readout.sv
module acov_readout #(
    parameter int NB         = 32,
    parameter int LAG_BINS   = 4,
    parameter int PHASE_BINS = 8,
    parameter int LAG_W      = 3,
    parameter int PH_W       = 4,
    parameter int CNT_W      = 21,
    parameter int SUM_W      = 32,
    parameter int PROD_W     = 44,
    parameter int RCNT_W     = 24,
    parameter int RSUM_W     = 35,
    parameter int RPROD_W    = 47
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NB-1:0][CNT_W-1:0]   cnt_mem,
    input  logic [NB-1:0][SUM_W-1:0]   s1_mem,
    input  logic [NB-1:0][SUM_W-1:0]   s2_mem,
    input  logic [NB-1:0][PROD_W-1:0]  p_mem,
    input  logic [LAG_W-1:0]           rd_lag,
    input  logic [PH_W-1:0]            rd_phase,
    input  logic                       rd_all,
    output logic [RCNT_W-1:0]          rd_count,
    output logic [RSUM_W-1:0]          rd_sum1,
    output logic [RSUM_W-1:0]          rd_sum2,
    output logic [RPROD_W-1:0]         rd_prod
);
    localparam logic [LAG_W-1:0] LAG_L = LAG_W'(LAG_BINS);
    localparam logic [PH_W-1:0]  PB_L  = PH_W'(PHASE_BINS);

    logic                 lag_ok, ph_ok;
    logic [RCNT_W-1:0]    acc_c;
    logic [RSUM_W-1:0]    acc_1, acc_2;
    logic [RPROD_W-1:0]   acc_p;

    always_comb begin
        lag_ok = rd_lag < LAG_L;
        ph_ok  = rd_all || (rd_phase < PB_L);
        acc_c  = '0;
        acc_1  = '0;
        acc_2  = '0;
        acc_p  = '0;
        for (int p = 0; p < PHASE_BINS; p++) begin
            if (lag_ok && ph_ok && (rd_all || (rd_phase == PH_W'(p)))) begin
                acc_c = acc_c + RCNT_W'(cnt_mem[int'(rd_lag) * PHASE_BINS + p]);
                acc_1 = acc_1 + RSUM_W'($signed(s1_mem[int'(rd_lag) * PHASE_BINS + p]));
                acc_2 = acc_2 + RSUM_W'($signed(s2_mem[int'(rd_lag) * PHASE_BINS + p]));
                acc_p = acc_p + RPROD_W'($signed(p_mem[int'(rd_lag) * PHASE_BINS + p]));
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_count <= '0;
            rd_sum1  <= '0;
            rd_sum2  <= '0;
            rd_prod  <= '0;
        end else begin
            rd_count <= acc_c;
            rd_sum1  <= acc_1;
            rd_sum2  <= acc_2;
            rd_prod  <= acc_p;
        end
    end

    // R7: an out-of-range read lag returns zeros one edge later
    a_r7_oor_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !lag_ok |=> (rd_count == '0 && rd_prod == '0 && rd_sum1 == '0));
endmodule

// File: rtl/acov_accum.sv
module acov_accum #(
    parameter int CODE_W     = 12,
    parameter int LAG_BINS   = 4,
    parameter int PHASE_BINS = 8,
    parameter int LOG_MAX_N  = 20,
    localparam int NB      = LAG_BINS * PHASE_BINS,
    localparam int IDX_W   = (NB > 1) ? $clog2(NB) : 1,
    localparam int LAG_W   = $clog2(LAG_BINS) + 1,
    localparam int PH_W    = $clog2(PHASE_BINS) + 1,
    localparam int PB_LOG  = $clog2(PHASE_BINS),
    localparam int CNT_W   = LOG_MAX_N + 1,
    localparam int SUM_W   = CODE_W + LOG_MAX_N,
    localparam int PROD_W  = 2 * CODE_W + LOG_MAX_N,
    localparam int RCNT_W  = CNT_W + PB_LOG,
    localparam int RSUM_W  = SUM_W + PB_LOG,
    localparam int RPROD_W = PROD_W + PB_LOG
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  logic [PH_W-1:0]     cycle_len,
    input  logic                single,
    input  logic                in_valid,
    input  logic [CODE_W-1:0]   in_x1,
    input  logic [CODE_W-1:0]   in_x2,
    input  logic [LAG_W-1:0]    in_lag,
    input  logic [PH_W-1:0]     in_phase,
    output logic                ready,
    output logic                err,
    input  logic [LAG_W-1:0]    rd_lag,
    input  logic [PH_W-1:0]     rd_phase,
    input  logic                rd_all,
    output logic [RCNT_W-1:0]   rd_count,
    output logic [RSUM_W-1:0]   rd_sum1,
    output logic [RSUM_W-1:0]   rd_sum2,
    output logic [RPROD_W-1:0]  rd_prod
);
    logic                       flush, wipe_en, accept, drop;
    logic [IDX_W-1:0]           wipe_idx;
    logic                       a_vld;
    logic [IDX_W-1:0]           a_idx;
    logic [CODE_W-1:0]          a_d1, a_d2;
    logic [2*CODE_W-1:0]        a_dp;
    logic [NB-1:0][CNT_W-1:0]   cnt_mem;
    logic [NB-1:0][SUM_W-1:0]   s1_mem, s2_mem;
    logic [NB-1:0][PROD_W-1:0]  p_mem;
    logic                       err_q;

    acov_ctrl #(.NB(NB), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ready(ready), .flush(flush),
        .wipe_en(wipe_en), .wipe_idx(wipe_idx)
    );

    assign accept = ready && !clr;

    acov_ingress #(
        .CODE_W(CODE_W), .LAG_BINS(LAG_BINS), .PHASE_BINS(PHASE_BINS),
        .LAG_W(LAG_W), .PH_W(PH_W), .IDX_W(IDX_W)
    ) u_ingress (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .accept(accept),
        .single(single), .cycle_len(cycle_len), .x1(in_x1), .x2(in_x2),
        .lag(in_lag), .phase(in_phase), .a_vld(a_vld), .a_idx(a_idx),
        .a_d1(a_d1), .a_d2(a_d2), .a_dp(a_dp), .drop(drop)
    );

    acov_bank #(
        .NB(NB), .IDX_W(IDX_W), .CODE_W(CODE_W), .CNT_W(CNT_W),
        .SUM_W(SUM_W), .PROD_W(PROD_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n), .a_vld(a_vld), .a_idx(a_idx), .a_d1(a_d1),
        .a_d2(a_d2), .a_dp(a_dp), .flush(flush), .wipe_en(wipe_en),
        .wipe_idx(wipe_idx), .cnt_mem(cnt_mem), .s1_mem(s1_mem),
        .s2_mem(s2_mem), .p_mem(p_mem)
    );

    acov_readout #(
        .NB(NB), .LAG_BINS(LAG_BINS), .PHASE_BINS(PHASE_BINS), .LAG_W(LAG_W),
        .PH_W(PH_W), .CNT_W(CNT_W), .SUM_W(SUM_W), .PROD_W(PROD_W),
        .RCNT_W(RCNT_W), .RSUM_W(RSUM_W), .RPROD_W(RPROD_W)
    ) u_readout (
        .clk(clk), .rst_n(rst_n), .cnt_mem(cnt_mem), .s1_mem(s1_mem),
        .s2_mem(s2_mem), .p_mem(p_mem), .rd_lag(rd_lag), .rd_phase(rd_phase),
        .rd_all(rd_all), .rd_count(rd_count), .rd_sum1(rd_sum1),
        .rd_sum2(rd_sum2), .rd_prod(rd_prod)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    err_q <= 1'b0;
        else if (clr)  err_q <= 1'b0;
        else if (drop) err_q <= 1'b1;
    end
    assign err = err_q;

    // R4: the error flag holds until a clear
    a_r4_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !clr) |=> err);
    // R4: a pair offered while accepting with a bad phase raises the flag
    a_r4_err_on_bad_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready && !clr && (in_phase >= cycle_len)) |=> err);
endmodule

// File: tb/acov_accum_tb.sv
module acov_accum_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LB = 4;
    localparam int PB = 8;
    localparam int NBINS = LB * PB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic [3:0]  cycle_len = 4'd8;
    logic        single = 1'b0;
    logic        in_valid = 1'b0;
    logic [11:0] in_x1 = '0, in_x2 = '0;
    logic [2:0]  in_lag = '0;
    logic [3:0]  in_phase = '0;
    logic        ready, err;
    logic [2:0]  rd_lag = '0;
    logic [3:0]  rd_phase = '0;
    logic        rd_all = 1'b0;
    logic [23:0] rd_count;
    logic [34:0] rd_sum1, rd_sum2;
    logic [46:0] rd_prod;

    acov_accum dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cycle_len(cycle_len),
        .single(single), .in_valid(in_valid), .in_x1(in_x1), .in_x2(in_x2),
        .in_lag(in_lag), .in_phase(in_phase), .ready(ready), .err(err),
        .rd_lag(rd_lag), .rd_phase(rd_phase), .rd_all(rd_all),
        .rd_count(rd_count), .rd_sum1(rd_sum1), .rd_sum2(rd_sum2),
        .rd_prod(rd_prod)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        longint c, s1, s2, p;
        int     due;
        string  tag;
    } exp_t;

    exp_t   sb_q[$];
    int     n_run = 0, n_fail = 0, edges = 0;
    bit     done = 1'b0;
    longint m_c[NBINS], m_1[NBINS], m_2[NBINS], m_p[NBINS];

    always @(posedge clk) edges <= edges + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // monitor: compares each read when its data is due
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= edges) begin
            exp_t e;
            longint ac, a1, a2, ap;
            e  = sb_q.pop_front();
            ac = longint'(rd_count);
            a1 = longint'($signed(rd_sum1));
            a2 = longint'($signed(rd_sum2));
            ap = longint'($signed(rd_prod));
            n_run++;
            if (ac != e.c || a1 != e.s1 || a2 != e.s2 || ap != e.p) begin
                n_fail++;
                $display("FAIL %s actual=(%0d,%0d,%0d,%0d) expected=(%0d,%0d,%0d,%0d)",
                         e.tag, ac, a1, a2, ap, e.c, e.s1, e.s2, e.p);
            end
        end
    end

    task automatic clear_model();
        for (int i = 0; i < NBINS; i++) begin
            m_c[i] = 0; m_1[i] = 0; m_2[i] = 0; m_p[i] = 0;
        end
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // driver: one pair per call; consecutive calls give back-to-back cycles
    task automatic send(input int x1, input int x2, input int lag, input int ph);
        int b;
        in_valid = 1'b1;
        in_x1 = 12'(x1); in_x2 = 12'(x2);
        in_lag = 3'(lag); in_phase = 4'(ph);
        if (ph < int'(cycle_len) && ph < PB) begin
            if (single) begin
                b = ph;
                m_c[b] += 1; m_1[b] += x1; m_p[b] += longint'(x1) * x1;
            end else if (lag < LB) begin
                b = lag * PB + ph;
                m_c[b] += 1; m_1[b] += x1; m_2[b] += x2; m_p[b] += longint'(x1) * x2;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic rd(input int lag, input int ph, input bit all, input string tag);
        exp_t e;
        e.c = 0; e.s1 = 0; e.s2 = 0; e.p = 0;
        if (lag < LB && (all || ph < PB)) begin
            for (int p = 0; p < PB; p++) begin
                if (all || p == ph) begin
                    e.c += m_c[lag*PB+p]; e.s1 += m_1[lag*PB+p];
                    e.s2 += m_2[lag*PB+p]; e.p += m_p[lag*PB+p];
                end
            end
        end
        rd_lag = 3'(lag); rd_phase = 4'(ph); rd_all = all;
        e.due = edges + 1;
        e.tag = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    initial begin
        int n;
        clear_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(ready == 1'b1, "R1 ready", longint'(ready), 1);
        chk(err == 1'b0, "R1 err", longint'(err), 0);
        rd(0, 0, 0, "R1 bin(0,0)");
        rd(3, 7, 0, "R1 bin(3,7)");
        rd(2, 0, 1, "R1 lag2 all");

        // R2: isolated pairs, including extreme codes
        send(100, -50, 0, 0);   idle(2);
        send(-7, 3, 1, 2);      idle(2);
        send(2047, -2048, 3, 7); idle(2);
        send(-2048, -2048, 2, 5); idle(2);
        send(-2048, -2048, 2, 5); idle(4);
        rd(0, 0, 0, "R2 bin(0,0)");
        rd(1, 2, 0, "R2 bin(1,2)");
        rd(3, 7, 0, "R2 bin(3,7) extremes");
        rd(2, 5, 0, "R2 bin(2,5) extremes");

        // R3: back-to-back updates to one bin, then interleaved
        send(11, 5, 1, 3); send(-20, 7, 1, 3); send(300, -300, 1, 3);
        send(1, 1, 1, 3);  send(-1, 2047, 1, 3); send(55, -9, 1, 3);
        send(4, 4, 2, 1); send(6, -2, 2, 1); send(9, 9, 0, 4); send(-3, 8, 2, 1);
        idle(4);
        rd(1, 3, 0, "R3 burst bin(1,3)");
        rd(2, 1, 0, "R3 interleaved bin(2,1)");
        rd(0, 4, 0, "R3 interleaved bin(0,4)");

        // R4: out-of-range pairs dropped and flagged
        cycle_len = 4'd5;
        send(10, 10, 1, 6);
        chk(err == 1'b1, "R4 err after bad phase", longint'(err), 1);
        send(1, 1, 4, 0);
        send(5, 6, 1, 1);
        idle(4);
        chk(err == 1'b1, "R4 err sticky", longint'(err), 1);
        rd(1, 6, 0, "R4 bin(1,6) untouched");
        rd(0, 0, 0, "R4 bin(0,0) untouched by bad lag");
        rd(1, 1, 0, "R4 valid pair after drop");

        // R5: one-sampler mode
        single = 1'b1;
        send(30, 999, 3, 2); send(-40, 7, 7, 2); send(3, 0, 0, 6);
        idle(4);
        single = 1'b0;
        rd(0, 2, 0, "R5 bin(0,2) sum2 unchanged");
        rd(3, 2, 0, "R5 bin(3,2) lag ignored");
        cycle_len = 4'd8;

        // R8: combined phase reads
        rd(1, 0, 1, "R8 lag1 all");
        rd(2, 3, 1, "R8 lag2 all");
        rd(0, 9, 1, "R8 lag0 all phase ignored");

        // R7: out-of-range reads
        rd(5, 0, 0, "R7 lag5");
        rd(0, 9, 0, "R7 phase9");

        // R6: clear pass
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        n = 0;
        while (!ready && n < 1000) begin
            n++;
            in_valid = (n == 3);
            in_x1 = 12'd77; in_x2 = 12'd77; in_lag = 3'd0; in_phase = 4'd1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(n == NBINS, "R6 ready low length", longint'(n), NBINS);
        chk(err == 1'b0, "R6 err cleared", longint'(err), 0);
        clear_model();
        idle(3);
        rd(1, 3, 0, "R6 bin(1,3) zero");
        rd(0, 1, 0, "R6 bin(0,1) ignored during wipe");
        rd(2, 0, 1, "R6 lag2 all zero");
        send(12, -12, 3, 3); idle(4);
        rd(3, 3, 0, "R6 accumulate after clear");

        idle(3);
        chk(sb_q.size() == 0, "scoreboard drained", longint'(sb_q.size()), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule